// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt request lines for a small processor core and decides, at each instruction boundary, whether one of them is to be serviced and which one. One line cannot be masked and is guarded against glitches: it needs both a rising edge and a level that is still high at the boundary. Three lines are vectored and individually maskable. One line of them latches on an edge, and the other two follow the input level. The fifth line is the lowest in rank and carries no vector of its own: when it wins, the block asks the core to fetch an instruction that the requesting device supplies, and it pulls an active-low acknowledge.

The four maskable lines also pass through a global enable. An enable command opens the gate only after the instruction that follows it has completed. A disable command closes the gate at once. Accepting any interrupt closes the gate again. A mask-write port loads the three mask bits and can discard a latched edge request. A status word reports the masks, the enable and the pending state of the three masked lines. Decoding the instruction stream and saving the return address stay in the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: At most one line is granted per boundary. When several lines are eligible, the rank from highest to lowest is nmi_req, edge_req, lvl_b_req, lvl_c_req, ext_req. take_line is one-hot, with bit 0 = nmi, bit 1 = edge, bit 2 = lvl_b, bit 3 = lvl_c and bit 4 = ext, and it is all zero when take_valid is low.
- R2: A grant presents vec_addr 0x0024 for nmi, 0x003C for edge, 0x0034 for lvl_b and 0x002C for lvl_c.
- R3: A grant of ext_req drives ext_fetch high, ack_n low and vec_addr to zero, for exactly the one cycle that take_valid is high.
- R4: nmi_req is granted whatever the enable and the masks are. It needs a rising edge followed by a level that is still high at the boundary. A pulse that has fallen before the boundary is dropped, and a level that stays high is granted only once.
- R5: Reset clears the enable and sets all three mask bits. While the enable is clear, the edge, lvl_b, lvl_c and ext lines are never granted.
- R6: en_cmd is sampled only together with instr_end. It leaves the boundary where it is sampled closed to maskable lines and opens the next boundary to them.
- R7: dis_cmd given with instr_end clears the enable, and that same boundary grants no maskable line.
- R8: Every grant, nmi included, clears the enable. A line that is still requesting is not granted again until a new enable command.
- R9: A rising edge on edge_req stays pending after the input falls. It is cleared when that line is granted, or by a mask write with edge_clr high.
- R10: lvl_b_req and lvl_c_req are not latched. A request that falls before the boundary is not granted.
- R11: A mask write with mask_apply high loads mask_val, with bit 2 masking edge, bit 1 masking lvl_b and bit 0 masking lvl_c. With mask_apply low, the masks keep their values. A masked line is never granted.
- R12: stat_word is laid out as follows: bits 2..0 are the masks in the order of R11, bit 3 is the enable, and bits 6, 5 and 4 are pending for edge, lvl_b and lvl_c.
- R13: Grants are decided only in cycles where instr_end is high. take_valid, take_line, vec_addr, ext_fetch and ack_n show the decision in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request, needs an edge and a level |
| edge_req | input | 1 | Maskable request, latched on a rising edge |
| lvl_b_req | input | 1 | Maskable level request, middle rank |
| lvl_c_req | input | 1 | Maskable level request, lower rank |
| ext_req | input | 1 | Maskable request served by a device-supplied instruction |
| instr_end | input | 1 | Marks the last cycle of an instruction |
| en_cmd | input | 1 | Enable command, sampled with instr_end |
| dis_cmd | input | 1 | Disable command, sampled with instr_end |
| mask_wr | input | 1 | Mask-write strobe |
| mask_apply | input | 1 | Load mask_val on this write |
| mask_val | input | 3 | New mask bits |
| edge_clr | input | 1 | Discard a latched edge request on this write |
| stat_word | output | 7 | Masks, enable and pending bits |
| take_valid | output | 1 | A grant was made at the last boundary |
| take_line | output | 5 | One-hot granted line |
| vec_addr | output | VEC_W | Vector address of the grant |
| ext_fetch | output | 1 | Core must fetch the device-supplied instruction |
| ack_n | output | 1 | Active-low acknowledge to the external device |

## Verification
The hardest case to reach is the timing of the enable window. It depends on the exact boundary at which the enable command is sampled, and on whether a request is already waiting when that boundary and the next one pass. The bench drives each boundary through one task that returns in the cycle where the decision becomes visible. It first holds a request through the enabling boundary, where nothing may be granted, and then checks the grant at the next boundary. It also stacks every line at once and re-enables after each grant, so the rank can be watched line by line. Finally it starts the edge line and the non-maskable line with pulses that end before a boundary, which separates edge latching from level sensing.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int NUM_SRC  = 5;
   localparam int NUM_RST  = 3;
   localparam int SRC_NMI  = 0;
   localparam int SRC_EDGE = 1;
   localparam int SRC_LVLB = 2;
   localparam int SRC_LVLC = 3;
   localparam int SRC_EXT  = 4;

   typedef enum logic [1:0] {
      LINE_NMI   = 2'd0,
      LINE_EDGE  = 2'd1,
      LINE_LEVEL = 2'd2
   } line_mode_e;
endpackage

// File: rtl/irq_line_cond.sv
module irq_line_cond
   import irq_prio_pkg::*;
#(
   parameter line_mode_e MODE        = LINE_LEVEL,
   parameter int         SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic clr_i,
   output logic pend_o
);
   logic req_s;

   // optional input synchronizer
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign req_s = req_i;
      end else begin : g_sync
         logic sh [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < SYNC_STAGES; k++) sh[k] <= 1'b0;
            end else begin
               sh[0] <= req_i;
               for (int k = 1; k < SYNC_STAGES; k++) sh[k] <= sh[k-1];
            end
         end
         assign req_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   generate
      if (MODE == LINE_LEVEL) begin : g_level
         logic unused_clr;
         assign unused_clr = clr_i;
         assign pend_o     = req_s;
      end else begin : g_latched
         logic prev_q, hold_q, rise;
         assign rise = req_s & ~prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= req_s;
         end
         if (MODE == LINE_NMI) begin : g_nmi
            // edge arms, level must persist until service
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                 hold_q <= 1'b0;
               else if (rise)              hold_q <= 1'b1;
               else if (clr_i || !req_s)   hold_q <= 1'b0;
            end
            assign pend_o = hold_q & req_s;
         end else begin : g_edge
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      hold_q <= 1'b0;
               else if (rise)   hold_q <= 1'b1;
               else if (clr_i)  hold_q <= 1'b0;
            end
            assign pend_o = hold_q;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary_i,
   input  logic set_cmd_i,
   input  logic clr_cmd_i,
   input  logic taken_i,
   output logic en_o,
   output logic window_o
);
   logic en_q, wait_q;

   // maskable lines may be granted at this boundary
   assign window_o = boundary_i & ~clr_cmd_i & (en_q | wait_q);
   assign en_o     = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         wait_q <= 1'b0;
      end else if (boundary_i) begin
         if (clr_cmd_i || taken_i) begin
            en_q   <= 1'b0;
            wait_q <= 1'b0;
         end else begin
            en_q   <= en_q | wait_q;
            wait_q <= set_cmd_i;
         end
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NUM_SRC = 5,
   parameter int VEC_W   = 16,
   parameter logic [NUM_SRC*VEC_W-1:0] VEC_TABLE = '0
) (
   input  logic [NUM_SRC-1:0] cand_i,
   output logic [NUM_SRC-1:0] win_o,
   output logic               any_o,
   output logic [VEC_W-1:0]   vec_o
);
   logic [NUM_SRC:0] above;
   assign above[0] = 1'b0;

   // index 0 ranks highest
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
         assign win_o[i]   = cand_i[i] & ~above[i];
         assign above[i+1] = above[i] | cand_i[i];
      end
   endgenerate

   assign any_o = above[NUM_SRC];

   always_comb begin
      vec_o = '0;
      for (int i = 0; i < NUM_SRC; i++)
         if (win_o[i]) vec_o = vec_o | VEC_TABLE[i*VEC_W +: VEC_W];
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int               VEC_W       = 16,
   parameter int               SYNC_STAGES = 0,
   parameter logic [VEC_W-1:0] NMI_VEC     = 'h24,
   parameter logic [VEC_W-1:0] EDGE_VEC    = 'h3C,
   parameter logic [VEC_W-1:0] LVLB_VEC    = 'h34,
   parameter logic [VEC_W-1:0] LVLC_VEC    = 'h2C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nmi_req,
   input  logic               edge_req,
   input  logic               lvl_b_req,
   input  logic               lvl_c_req,
   input  logic               ext_req,
   input  logic               instr_end,
   input  logic               en_cmd,
   input  logic               dis_cmd,
   input  logic               mask_wr,
   input  logic               mask_apply,
   input  logic [2:0]         mask_val,
   input  logic               edge_clr,
   output logic [6:0]         stat_word,
   output logic               take_valid,
   output logic [4:0]         take_line,
   output logic [VEC_W-1:0]   vec_addr,
   output logic               ext_fetch,
   output logic               ack_n
);
   localparam logic [NUM_SRC*VEC_W-1:0] VEC_TABLE =
      {{VEC_W{1'b0}}, LVLC_VEC, LVLB_VEC, EDGE_VEC, NMI_VEC};

   generate
      if (VEC_W < 6) begin : g_bad_width
         $error("irq_prio_ctrl: VEC_W must be at least 6");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("irq_prio_ctrl: SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic               ien, en_window, nmi_pend, taken, any;
   logic [NUM_SRC-1:0] cand, win;
   logic [NUM_RST-1:0] rst_in, rst_pend, rst_clr;
   logic [2:0]         mask_q;
   logic [VEC_W-1:0]   vec_next;

   assign rst_in = {lvl_c_req, lvl_b_req, edge_req};

   irq_line_cond #(.MODE(LINE_NMI), .SYNC_STAGES(SYNC_STAGES)) u_nmi (
      .clk(clk), .rst_n(rst_n), .req_i(nmi_req),
      .clr_i(taken & win[SRC_NMI]), .pend_o(nmi_pend)
   );

   // three maskable vectored lines: first one edge-latched, rest level
   generate
      for (genvar j = 0; j < NUM_RST; j++) begin : g_rst
         localparam line_mode_e LM = (j == 0) ? LINE_EDGE : LINE_LEVEL;
         if (j == 0) begin : g_clr_edge
            assign rst_clr[j] = (taken & win[SRC_EDGE]) | (mask_wr & edge_clr);
         end else begin : g_clr_lvl
            assign rst_clr[j] = taken & win[1+j];
         end
         irq_line_cond #(.MODE(LM), .SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk(clk), .rst_n(rst_n), .req_i(rst_in[j]),
            .clr_i(rst_clr[j]), .pend_o(rst_pend[j])
         );
         assign cand[1+j] = rst_pend[j] & ~mask_q[2-j] & en_window;
      end
   endgenerate

   assign cand[SRC_NMI] = nmi_pend & instr_end;
   assign cand[SRC_EXT] = ext_req & en_window;
   assign taken         = instr_end & any;

   irq_enable_ff u_en (
      .clk(clk), .rst_n(rst_n), .boundary_i(instr_end),
      .set_cmd_i(en_cmd), .clr_cmd_i(dis_cmd), .taken_i(taken),
      .en_o(ien), .window_o(en_window)
   );

   irq_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_TABLE(VEC_TABLE)) u_pick (
      .cand_i(cand), .win_o(win), .any_o(any), .vec_o(vec_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q <= 3'b111;
      else if (mask_wr && mask_apply) mask_q <= mask_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_valid <= 1'b0;
         take_line  <= '0;
         vec_addr   <= '0;
         ext_fetch  <= 1'b0;
         ack_n      <= 1'b1;
      end else begin
         take_valid <= taken;
         take_line  <= taken ? win : '0;
         vec_addr   <= taken ? vec_next : '0;
         ext_fetch  <= taken & win[SRC_EXT];
         ack_n      <= ~(taken & win[SRC_EXT]);
      end
   end

   assign stat_word = {rst_pend[0], rst_pend[1], rst_pend[2], ien, mask_q};
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int               VEC_W   = 16,
   parameter logic [VEC_W-1:0] NMI_VEC = 'h24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             instr_end,
   input logic             dis_cmd,
   input logic             en_window,
   input logic [6:0]       stat_word,
   input logic             take_valid,
   input logic [4:0]       take_line,
   input logic [VEC_W-1:0] vec_addr,
   input logic             ext_fetch,
   input logic             ack_n
);
   // R13
   take_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_valid |-> $past(instr_end));

   // R1
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_valid |-> $onehot(take_line));

   // R1
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_valid |-> (take_line == '0));

   // R8
   clear_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_valid |-> !stat_word[3]);

   // R5
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && !take_line[0]) |-> $past(en_window));

   // R7
   di_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dis_cmd && instr_end) |-> !stat_word[3]);

   // R3
   ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> (ext_fetch && take_valid && take_line[4] && vec_addr == '0));

   // R2
   nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_valid && take_line[0]) |-> (vec_addr == NMI_VEC));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) chk_i (
   .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .dis_cmd(dis_cmd),
   .en_window(en_window), .stat_word(stat_word), .take_valid(take_valid),
   .take_line(take_line), .vec_addr(vec_addr), .ext_fetch(ext_fetch),
   .ack_n(ack_n)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_req = 0, edge_req = 0, lvl_b_req = 0, lvl_c_req = 0, ext_req = 0;
   logic        instr_end = 0, en_cmd = 0, dis_cmd = 0;
   logic        mask_wr = 0, mask_apply = 0, edge_clr = 0;
   logic [2:0]  mask_val = '0;
   logic [6:0]  stat_word;
   logic        take_valid, ext_fetch, ack_n;
   logic [4:0]  take_line;
   logic [15:0] vec_addr;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .edge_req(edge_req),
      .lvl_b_req(lvl_b_req), .lvl_c_req(lvl_c_req), .ext_req(ext_req),
      .instr_end(instr_end), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
      .mask_wr(mask_wr), .mask_apply(mask_apply), .mask_val(mask_val),
      .edge_clr(edge_clr), .stat_word(stat_word), .take_valid(take_valid),
      .take_line(take_line), .vec_addr(vec_addr), .ext_fetch(ext_fetch),
      .ack_n(ack_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one instruction boundary; returns where the decision is visible
   task automatic boundary(input logic en, input logic dis);
      instr_end = 1; en_cmd = en; dis_cmd = dis;
      @(posedge clk);
      @(negedge clk);
      instr_end = 0; en_cmd = 0; dis_cmd = 0;
   endtask

   task automatic mask_write(input logic apply, input logic [2:0] val, input logic eclr);
      mask_wr = 1; mask_apply = apply; mask_val = val; edge_clr = eclr;
      @(posedge clk);
      @(negedge clk);
      mask_wr = 0; mask_apply = 0; edge_clr = 0;
   endtask

   task automatic open_gate();
      boundary(1, 0);
      boundary(0, 0);
   endtask

   task automatic t_reset();
      chk("R5 reset status", {25'd0, stat_word}, 32'h07);
      chk("R12 reset take", {31'd0, take_valid}, 0);
      chk("R3 reset ack_n", {31'd0, ack_n}, 1);
   endtask

   task automatic t_disabled();
      mask_write(1, 3'b000, 0);
      chk("R11 unmask all", {25'd0, stat_word}, 32'h00);
      lvl_c_req = 1;
      idle(1);
      chk("R12 lvl_c pending bit", {25'd0, stat_word}, 32'h10);
      boundary(0, 0);
      chk("R5 disabled no grant", {31'd0, take_valid}, 0);
   endtask

   task automatic t_ei_delay();
      boundary(1, 0);
      chk("R6 enabling boundary closed", {31'd0, take_valid}, 0);
      boundary(0, 0);
      chk("R6 next boundary grants", {27'd0, take_line}, 32'h08);
      chk("R2 lvl_c vector", {16'd0, vec_addr}, 32'h2C);
      chk("R8 enable cleared", {25'd0, stat_word}, 32'h10);
      boundary(0, 0);
      chk("R8 no regrant", {31'd0, take_valid}, 0);
      lvl_c_req = 0;
   endtask

   task automatic t_priority();
      lvl_b_req = 1; lvl_c_req = 1; ext_req = 1; edge_req = 1;
      idle(1);
      open_gate();
      chk("R1 edge wins", {27'd0, take_line}, 32'h02);
      chk("R2 edge vector", {16'd0, vec_addr}, 32'h3C);
      chk("R9 edge latch cleared by grant", {25'd0, stat_word}, 32'h30);
      open_gate();
      chk("R1 lvl_b next", {27'd0, take_line}, 32'h04);
      chk("R2 lvl_b vector", {16'd0, vec_addr}, 32'h34);
      lvl_b_req = 0;
      open_gate();
      chk("R1 lvl_c next", {27'd0, take_line}, 32'h08);
      lvl_c_req = 0;
      open_gate();
      chk("R1 ext last", {27'd0, take_line}, 32'h10);
      chk("R3 ext_fetch", {31'd0, ext_fetch}, 1);
      chk("R3 ack_n low", {31'd0, ack_n}, 0);
      chk("R3 vector zero", {16'd0, vec_addr}, 0);
      idle(1);
      chk("R3 ack one cycle", {30'd0, ack_n, take_valid}, 32'h2);
      ext_req = 0; edge_req = 0;
   endtask

   task automatic t_mask();
      mask_write(1, 3'b010, 0);
      lvl_b_req = 1;
      open_gate();
      chk("R11 masked no grant", {31'd0, take_valid}, 0);
      chk("R12 status masked", {25'd0, stat_word}, 32'h2A);
      mask_write(0, 3'b000, 0);
      chk("R11 apply low keeps", {25'd0, stat_word}, 32'h2A);
      boundary(0, 0);
      chk("R11 still masked", {31'd0, take_valid}, 0);
      mask_write(1, 3'b000, 0);
      boundary(0, 0);
      chk("R11 unmasked grant", {27'd0, take_line}, 32'h04);
      lvl_b_req = 0;
   endtask

   task automatic t_edge();
      mask_write(1, 3'b100, 0);
      edge_req = 1; idle(1); edge_req = 0; idle(2);
      chk("R9 edge held after fall", {25'd0, stat_word}, 32'h44);
      mask_write(0, 3'b000, 1);
      chk("R9 edge_clr discards", {25'd0, stat_word}, 32'h04);
      edge_req = 1; idle(1); edge_req = 0; idle(1);
      mask_write(1, 3'b000, 0);
      open_gate();
      chk("R9 latched edge granted", {27'd0, take_line}, 32'h02);
      chk("R9 status after grant", {25'd0, stat_word}, 32'h00);
   endtask

   task automatic t_level_drop();
      open_gate();
      chk("R6 gate open", {25'd0, stat_word}, 32'h08);
      lvl_c_req = 1; idle(2); lvl_c_req = 0;
      boundary(0, 0);
      chk("R10 dropped level ignored", {31'd0, take_valid}, 0);
   endtask

   task automatic t_no_boundary();
      int seen = 0;
      lvl_c_req = 1;
      for (int i = 0; i < 5; i++) begin
         idle(1);
         if (take_valid) seen++;
      end
      chk("R13 no grant between boundaries", seen, 0);
      boundary(0, 0);
      chk("R13 grant at boundary", {27'd0, take_line}, 32'h08);
      lvl_c_req = 0;
   endtask

   task automatic t_di();
      open_gate();
      lvl_b_req = 1;
      boundary(0, 1);
      chk("R7 disable blocks grant", {31'd0, take_valid}, 0);
      chk("R7 enable cleared", {25'd0, stat_word}, 32'h20);
      boundary(0, 0);
      chk("R7 stays closed", {31'd0, take_valid}, 0);
      lvl_b_req = 0;
   endtask

   task automatic t_nmi();
      mask_write(1, 3'b111, 0);
      nmi_req = 1; idle(1); nmi_req = 0;
      boundary(0, 0);
      chk("R4 short pulse dropped", {31'd0, take_valid}, 0);
      nmi_req = 1; idle(1);
      boundary(0, 0);
      chk("R4 nmi granted while closed", {27'd0, take_line}, 32'h01);
      chk("R2 nmi vector", {16'd0, vec_addr}, 32'h24);
      boundary(0, 0);
      chk("R4 held level once", {31'd0, take_valid}, 0);
      nmi_req = 0;
      mask_write(1, 3'b000, 0);
      open_gate();
      lvl_c_req = 1; ext_req = 1; nmi_req = 1;
      idle(1);
      boundary(0, 0);
      chk("R1 nmi beats all", {27'd0, take_line}, 32'h01);
      chk("R8 nmi clears enable", {28'd0, stat_word[3:0]}, 32'h0);
      lvl_c_req = 0; ext_req = 0; nmi_req = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_ei_delay();
      t_priority();
      t_mask();
      t_edge();
      t_level_drop();
      t_no_boundary();
      t_di();
      t_nmi();
      idle(2);
      finish_run();
   end
endmodule